// File: doc/BRIEF.md
# Four-lane symmetric 11-tap FIR filter

This block is a single-clock FIR filter that handles a sample stream four times faster than its clock. In each cycle it accepts a group of four consecutive signed samples and returns four consecutive filtered samples. The effective sample rate is therefore four samples per clock: a 72 MHz clock carries a 288 MHz single-rate stream. The 11 coefficients are symmetric and are fixed by a parameter that lists only the six distinct values. Each output lane adds its mirrored sample pairs before multiplying, so it needs five pre-added products and one centre product.

The block keeps the ten most recent accepted samples from earlier groups. This lets every lane build its full 11-sample window, including windows that reach back across group boundaries. Cycles with the input strobe low are skipped: no sample enters the stream and the history does not move. The datapath has three register stages: pre-add, multiply, and sum with rounding and saturation. This gives a fixed latency. After that latency a continuous input stream gives a continuous output stream.

Top module: `fir4_sym_top`

## Requirements
- R1: While reset is high, and in the cycle after it, `out_valid` is 0. After reset, the sample history is zero, so the first outputs are computed as though all earlier samples were 0.
- R2: Lane 0 of `in_data` (bits 15:0) is the oldest sample of a group and lane 3 (bits 63:48) is the newest. The output lane n (bits 16n+15:16n) is y[i] = sum over k=0..10 of c[k]·x[i−k], where x[i] is the input sample that sits in that lane's position in the serialized stream.
- R3: The windows cross group boundaries. Outputs use the ten samples of the preceding accepted groups, so an impulse in lane 3 shows up in the outputs of the next groups.
- R4: A group accepted at a rising edge produces `out_valid` high exactly three edges later. `out_valid` is never high at any other time.
- R5: When `in_valid` is held high, `out_valid` stays high without gaps once the pipeline is full.
- R6: A cycle with `in_valid` low contributes no sample. Its `in_data` has no effect on any later output, and the history is left unchanged.
- R7: The full-precision sum is rounded by adding 2^14 and then arithmetically shifting right by 15 bits. Halves therefore round toward plus infinity.
- R8: A rounded result above 32767 is output as 32767. A result below −32768 is output as −32768.
- R9: The coefficients are c[k] = c[10−k]. The parameter `HALF_COEFS` holds c[0] in bits 15:0 up to c[5], the centre tap, in bits 95:80, each as a 16-bit signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input group is valid this cycle |
| in_data | input | 64 | Four signed 16-bit samples, lane 0 = oldest |
| out_valid | output | 1 | The output group is valid |
| out_data | output | 64 | Four signed 16-bit filtered samples, lane 0 = oldest |

## Verification
Assertions check on every cycle that the valid strobe follows the input strobe with a delay of three cycles, both when it fills and at its origin. They also check that the history holds still on idle cycles and takes the newest lane on accepted ones. The numerical results can only be shown by the bench scenarios, which compare each lane with a scalar convolution of the serialized stream. These scenarios cover the lane order, windows that cross group boundaries, rounding of small values, saturation at both rails, gapped input, and a reset in the middle of a stream.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
    localparam int LANES = 4;
    localparam int TAPS  = 11;
    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int SHIFT = 15;
    localparam int PIPE  = 3;

    localparam int HALF  = (TAPS + 1) / 2;
    localparam int HIST  = TAPS - 1;
    localparam int WIN   = HIST + LANES;
    localparam int PW    = DW + 1;
    localparam int MW    = PW + CW;
    localparam int AW    = MW + $clog2(HALF) + 1;

    typedef logic signed [DW-1:0] sample_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [PW-1:0] pre_t;
    typedef logic signed [MW-1:0] prod_t;
    typedef logic signed [AW-1:0] acc_t;

    localparam acc_t SAT_HI = acc_t'((2 ** (DW - 1)) - 1);
    localparam acc_t SAT_LO = acc_t'(-(2 ** (DW - 1)));
    localparam acc_t RND    = acc_t'(2 ** (SHIFT - 1));

    // round half up, then clamp to the sample range
    function automatic sample_t round_sat(input acc_t a);
        acc_t r;
        r = (a + RND) >>> SHIFT;
        if (r > SAT_HI)      return sample_t'(SAT_HI);
        else if (r < SAT_LO) return sample_t'(SAT_LO);
        else                 return sample_t'(r);
    endfunction
endpackage

// File: rtl/fir4_history.sv
module fir4_history
    import fir4_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_data,
    output logic [WIN*DW-1:0]     win_bus
);
    // element 0 = oldest stored sample
    logic [HIST*DW-1:0] hist_q;

    assign win_bus = {in_data, hist_q};

    always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (in_valid) hist_q <= win_bus[LANES*DW +: HIST*DW];
    end

    // R6: idle cycles leave the history untouched
    assert_hist_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> $stable(hist_q));

    // R3: an accepted group leaves its newest lane as the newest history entry
    assert_hist_newest_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst)) |->
            (hist_q[(HIST-1)*DW +: DW] == $past(in_data[(LANES-1)*DW +: DW])));
endmodule

// File: rtl/fir4_lane.sv
module fir4_lane
    import fir4_pkg::*;
#(
    parameter logic [HALF*CW-1:0] HALF_COEFS = '0
)(
    input  logic               clk,
    input  logic [TAPS*DW-1:0] taps,   // element 0 = oldest, TAPS-1 = current
    output sample_t            y
);
    pre_t  pre_d  [HALF];
    pre_t  pre_q  [HALF];
    prod_t prod_q [HALF];
    acc_t  acc_d;

    function automatic sample_t tap_at(input logic [TAPS*DW-1:0] t, input int i);
        return sample_t'(t[i*DW +: DW]);
    endfunction

    generate
        for (genvar k = 0; k < HALF; k++) begin : g_pre
            if (k == HALF - 1) begin : g_centre
                assign pre_d[k] = pre_t'(tap_at(taps, k));
            end else begin : g_pair
                assign pre_d[k] = pre_t'(tap_at(taps, TAPS - 1 - k)) + pre_t'(tap_at(taps, k));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int k = 0; k < HALF; k++) begin
            pre_q[k]  <= pre_d[k];
            prod_q[k] <= prod_t'(pre_q[k]) * prod_t'(coef_t'(HALF_COEFS[k*CW +: CW]));
        end
        y <= round_sat(acc_d);
    end

    always_comb begin
        acc_d = '0;
        for (int k = 0; k < HALF; k++) acc_d = acc_d + acc_t'(prod_q[k]);
    end
endmodule

// File: rtl/fir4_sym_top.sv
module fir4_sym_top
    import fir4_pkg::*;
#(
    parameter logic [HALF*CW-1:0] HALF_COEFS =
        {16'sd20000, 16'sd9800, -16'sd4200, 16'sd1800, -16'sd700, 16'sd200}
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [LANES*DW-1:0] in_data,
    output logic                out_valid,
    output logic [LANES*DW-1:0] out_data
);
    logic [WIN*DW-1:0] win_bus;
    logic [PIPE-1:0]   vld_q;

    fir4_history u_hist (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data), .win_bus(win_bus)
    );

    generate
        for (genvar n = 0; n < LANES; n++) begin : g_lane
            sample_t y_n;
            fir4_lane #(.HALF_COEFS(HALF_COEFS)) u_lane (
                .clk(clk),
                .taps(win_bus[n*DW +: TAPS*DW]),
                .y(y_n)
            );
            assign out_data[n*DW +: DW] = y_n;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[PIPE-2:0], in_valid};
    end
    assign out_valid = vld_q[PIPE-1];

    // R4: an accepted group appears three edges later
    assert_valid_fill_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##2 out_valid);

    // R4: output valid only ever comes from an input strobe three cycles before
    assert_valid_origin_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    // R1: output valid is low in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/test_fir4_sym_top.sv
module test_fir4_sym_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;

    always #2.5 clk = ~clk;

    fir4_sym_top i_fir4_sym_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int hc [6] = '{200, -700, 1800, -4200, 9800, 20000};
    int rh [10];
    int checks = 0, fails = 0;
    int cyc = 0;
    bit done = 0;
    bit    exp_v [8];
    int    exp_d [8][4];
    string exp_t [8];

    function automatic int coef(input int k);
        return (k <= 5) ? hc[k] : hc[10 - k];
    endfunction

    function automatic int rsat(input longint acc);
        longint r;
        r = (acc + 16384) >>> 15;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic check_outputs();
        int s = cyc % 8;
        checks++;
        if (out_valid !== exp_v[s]) begin
            fails++;
            $display("FAIL %s/R4 cycle %0d out_valid=%0b expected %0b", exp_t[s], cyc, out_valid, exp_v[s]);
        end
        if (exp_v[s] && out_valid) begin
            for (int n = 0; n < 4; n++) begin
                int act = int'($signed(out_data[n*16 +: 16]));
                checks++;
                if (act != exp_d[s][n]) begin
                    fails++;
                    $display("FAIL %s cycle %0d lane %0d actual %0d expected %0d", exp_t[s], cyc, n, act, exp_d[s][n]);
                end
            end
        end
        exp_v[s] = 0;
    endtask

    // one cycle: check, then drive the next group
    task automatic step(input bit v, input logic [63:0] d, input string tag);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_data  = d;
        if (v) begin
            int w [14];
            int s = (cyc + 3) % 8;
            for (int i = 0; i < 10; i++) w[i] = rh[i];
            for (int n = 0; n < 4; n++) w[10 + n] = int'($signed(d[n*16 +: 16]));
            for (int n = 0; n < 4; n++) begin
                longint acc = 0;
                for (int k = 0; k < 11; k++) acc += longint'(coef(k)) * longint'(w[10 + n - k]);
                exp_d[s][n] = rsat(acc);
            end
            exp_v[s] = 1;
            exp_t[s] = tag;
            for (int i = 0; i < 10; i++) rh[i] = w[i + 4];
        end
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_outputs();
        rst = 1; in_valid = 0;
        for (int i = 0; i < 8; i++) begin exp_v[i] = 0; exp_t[i] = "R1"; end
        for (int i = 0; i < 10; i++) rh[i] = 0;
        cyc++;
        @(negedge clk);
        check_outputs();
        cyc++;
        rst = 0;
    endtask

    function automatic logic [63:0] pack4(input int a, input int b, input int c, input int e);
        return {16'(e), 16'(c), 16'(b), 16'(a)};
    endfunction

    function automatic logic [63:0] rnd_group(input int mag);
        logic [63:0] g;
        for (int n = 0; n < 4; n++) g[n*16 +: 16] = 16'(int'($urandom_range(2*mag, 0)) - mag);
        return g;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin exp_v[i] = 0; exp_t[i] = "R1"; end
        for (int i = 0; i < 10; i++) rh[i] = 0;
        repeat (3) @(posedge clk);
        do_reset();
        // R1: first outputs see zero history; R9 impulse response shows symmetric taps
        step(1, pack4(16384, 0, 0, 0), "R1");
        for (int i = 0; i < 4; i++) step(1, 64'd0, "R9");
        // R3: impulse in lane 3 crosses into later groups
        step(1, pack4(0, 0, 0, 32767), "R3");
        for (int i = 0; i < 4; i++) step(1, 64'd0, "R3");
        // R2 and R5: continuous random stream
        for (int i = 0; i < 200; i++) step(1, rnd_group(32768 - 1), "R5");
        // R6: gapped stream with junk on idle cycles
        for (int i = 0; i < 200; i++) begin
            bit v = ($urandom_range(1, 0) == 1);
            step(v, v ? rnd_group(20000) : 64'hDEAD_BEEF_A5A5_5A5A, "R6");
        end
        // R7: small values exercise rounding
        for (int i = 0; i < 150; i++) step(1, rnd_group(4), "R7");
        // R8: saturation at both rails
        for (int i = 0; i < 6; i++) step(1, pack4(32767, 32767, 32767, 32767), "R8");
        for (int i = 0; i < 6; i++) step(1, pack4(-32768, -32768, -32768, -32768), "R8");
        for (int i = 0; i < 4; i++) step(1, pack4(32767, -32768, 32767, -32768), "R8");
        // R1: reset in mid-stream, then history is zero again
        for (int i = 0; i < 3; i++) step(1, rnd_group(30000), "R2");
        do_reset();
        step(1, pack4(0, 0, 16384, 0), "R1");
        for (int i = 0; i < 3; i++) step(1, 64'd0, "R1");
        // R2: lane order with a ramp
        for (int i = 0; i < 30; i++) step(1, pack4(4*i*100, (4*i+1)*100, (4*i+2)*100, (4*i+3)*100), "R2");
        for (int i = 0; i < 5; i++) step(0, 64'd0, "R4");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule